// File: doc/BRIEF.md
# Keyed Soft Reset Controller

This block sits on a simple word-addressed register port and lets software request a reset of the whole chip. The reset is guarded so that a stray store cannot fire it. Software first writes a 16-bit key, together with an enable bit, into an access register. That arms the block. A following write that clears bit 0 of the reset register then starts the reset request.

The request leaves the block as a pulse of a fixed, parameterised number of clock cycles. When the pulse ends, the block locks itself again and the reset bit returns to 1. A second reset therefore needs a new unlock.

Every bus access is answered one cycle after it is presented. Reads show the lock state and the reset bit. Reads never show the key.

Top module: `softrst_ctrl`

## Requirements
- R1: After reset, chipRstReq is 0, byte offset 0 reads 0 (locked) and byte offset 4 reads 1 in bit 0.
- R2: rspReady is 1 in exactly the cycle after a cycle with reqValid high, and 0 after a cycle with reqValid low.
- R3: A write to offset 0 whose bits [23:8] equal 0xA5A5 and whose bit 0 is 1 unlocks the block. A read of offset 0 then returns 1 in bit 0, and every read returns 0 in bits [31:1].
- R4: A write to offset 0 with a different key, or with bit 0 clear, leaves the block locked. It also clears an unlock made earlier.
- R5: While the block is locked, a write of 0 in bit 0 to offset 4 is ignored: no pulse is produced and offset 4 still reads 1.
- R6: While the block is unlocked, a write to offset 4 with bit 0 clear raises chipRstReq from the cycle after the write. chipRstReq stays high for exactly PULSE_LEN cycles (default 16), and offset 4 reads 0 during the pulse.
- R7: When the pulse ends, the block is locked (offset 0 reads 0) and offset 4 reads 1. Another reset needs a new unlock.
- R8: While the block is unlocked, a write of 1 in bit 0 to offset 4 produces no pulse and keeps the block unlocked.
- R9: During a pulse, writes to offset 0 and to offset 4 are ignored. They neither change the lock state nor lengthen the pulse.
- R10: Writes to any offset other than 0 and 4 have no effect, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access presented this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset of the access |
| reqWdata | input | DATA_W | Write data |
| rspReady | output | 1 | Access completed (one cycle after presentation) |
| rspRdata | output | DATA_W | Read data, valid with rspReady |
| chipRstReq | output | 1 | Chip reset request pulse |

## Verification
The bench works on the lock.

- It tries near-miss keys, the right key with the enable bit clear, and a bad key written after a good one. A design that compares the key loosely, or that keeps an older unlock, would fire a reset here.
- It counts the pulse cycle by cycle and issues writes in the middle of the pulse. A counter that is off by one would show up as a wrong count. So would a pulse that retriggers or gets re-armed during the reset.
- It checks that the block is locked again after the pulse.
- It writes to unmapped offsets, including an unaligned one. A design that decodes only part of the address would alias those writes onto the reset register.

// File: rtl/softrst_pkg.sv
package softrst_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'hA5A5;
  localparam int KEY_LSB = 8;
  localparam int ACC_OFF = 0;
  localparam int SOFT_OFF = 4;

  typedef struct packed {
    logic trig;    // start a reset pulse
    logic rdAcc;   // read of the access register
    logic rdSoft;  // read of the soft-reset register
  } ctlStb_t;
endpackage

// File: rtl/softrst_ctl.sv
module softrst_ctl
  import softrst_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              busy,
  input  logic              pulseDone,
  output logic              lockOpen,
  output logic              rspReady,
  output ctlStb_t           stb
);
  logic accHit, softHit, wrAcc, wrSoft, keyOk;

  assign accHit  = reqValid && (reqAddr == ADDR_W'(ACC_OFF));
  assign softHit = reqValid && (reqAddr == ADDR_W'(SOFT_OFF));
  assign wrAcc   = accHit && reqWrite && !busy;
  assign wrSoft  = softHit && reqWrite && !busy;
  assign keyOk   = (reqWdata[KEY_LSB +: 16] == UNLOCK_KEY) && reqWdata[0];

  always_comb begin
    stb        = '0;
    stb.trig   = wrSoft && lockOpen && !reqWdata[0];
    stb.rdAcc  = accHit && !reqWrite;
    stb.rdSoft = softHit && !reqWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockOpen <= 1'b0;
      rspReady <= 1'b0;
    end else begin
      rspReady <= reqValid;
      if (pulseDone)  lockOpen <= 1'b0;
      else if (wrAcc) lockOpen <= keyOk;
    end
  end
endmodule

// File: rtl/softrst_dp.sv
module softrst_dp
  import softrst_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic              lockOpen,
  output logic              busy,
  output logic              pulseDone,
  output logic              chipRstReq,
  output logic [DATA_W-1:0] rspRdata
);
  localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0]  cnt;
  logic              rstBit;
  logic [DATA_W-1:0] rdNext;

  assign pulseDone  = busy && (cnt == '0);
  assign chipRstReq = busy;

  always_comb begin
    rdNext = '0;
    if (stb.rdAcc)  rdNext[0] = lockOpen;
    if (stb.rdSoft) rdNext[0] = rstBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cnt      <= '0;
      rstBit   <= 1'b1;
      rspRdata <= '0;
    end else begin
      rspRdata <= rdNext;
      if (stb.trig && !busy) begin
        busy   <= 1'b1;
        cnt    <= CNT_LOAD;
        rstBit <= 1'b0;
      end else if (pulseDone) begin
        busy   <= 1'b0;
        rstBit <= 1'b1;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/softrst_ctrl.sv
module softrst_ctrl
  import softrst_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspReady,
  output logic [DATA_W-1:0] rspRdata,
  output logic              chipRstReq
);
  ctlStb_t stb;
  logic    lockOpen, busy, pulseDone;

  softrst_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy),
    .pulseDone(pulseDone), .lockOpen(lockOpen), .rspReady(rspReady),
    .stb(stb)
  );

  softrst_dp #(.DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lockOpen(lockOpen), .busy(busy),
    .pulseDone(pulseDone), .chipRstReq(chipRstReq), .rspRdata(rspRdata)
  );
endmodule

// File: rtl/softrst_chk.sv
module softrst_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PULSE_LEN = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              rspReady,
  input logic [DATA_W-1:0] rspRdata,
  input logic              chipRstReq,
  input logic              lockOpen
);
  int hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           hiCnt <= 0;
    else if (chipRstReq) hiCnt <= hiCnt + 1;
    else                 hiCnt <= 0;
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspReady); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspReady); // R2
  AST_KEY_HIDDEN: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> (rspRdata[DATA_W-1:1] == '0)); // R3
  AST_PULSE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chipRstReq) |-> $past(lockOpen)); // R5
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    chipRstReq |-> (hiCnt < PULSE_LEN)); // R6
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chipRstReq) |-> (hiCnt == PULSE_LEN)); // R6
  AST_RELOCK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chipRstReq) |-> !lockOpen); // R7
endmodule

bind softrst_ctrl softrst_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)
) u_chk (.*);

// File: tb/test_softrst_ctrl.sv
module test_softrst_ctrl;
  localparam int PLEN = 16;
  localparam logic [31:0] GOOD = 32'h00A5A501;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [3:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspReady;
  logic [31:0] rspRdata;
  logic        chipRstReq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  softrst_ctrl #(.ADDR_W(4), .DATA_W(32), .PULSE_LEN(PLEN)) i_softrst_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspReady(rspReady),
    .rspRdata(rspRdata), .chipRstReq(chipRstReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // starts and ends at a falling edge
  task automatic busOp(input bit wr, input logic [3:0] a, input logic [31:0] d,
                       output logic [31:0] rd);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    chk("R2 ready after access", 32'(rspReady), 32'd1);
    rd = rspRdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] rd;
    busOp(1'b1, a, d, rd);
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] rd;
    busOp(1'b0, a, '0, rd);
    chk(tag, rd, exp);
  endtask

  task automatic idleNoPulse(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      chk(tag, 32'(chipRstReq), 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic countHigh(inout int n);
    while (chipRstReq && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 no request after reset", 32'(chipRstReq), 32'd0);
    rdChk("R1 access reg locked", 4'd0, 32'd0);
    rdChk("R1 soft bit is 1", 4'd4, 32'd1);
    @(negedge clk);
    chk("R2 no ready when idle", 32'(rspReady), 32'd0);
  endtask

  task automatic t_locked;
    wr(4'd4, 32'h0);
    idleNoPulse("R5 locked write ignored", 3);
    rdChk("R5 soft bit still 1", 4'd4, 32'd1);
  endtask

  task automatic t_badKeys;
    wr(4'd0, 32'h00A5A401);
    rdChk("R4 wrong key stays locked", 4'd0, 32'd0);
    wr(4'd0, 32'h00A5A500);
    rdChk("R4 enable clear stays locked", 4'd0, 32'd0);
    wr(4'd0, GOOD);
    rdChk("R3 good key unlocks", 4'd0, 32'd1);
    wr(4'd0, 32'h0025A501);
    rdChk("R4 bad key relocks", 4'd0, 32'd0);
    wr(4'd4, 32'h0);
    idleNoPulse("R4 no pulse after relock", 3);
  endtask

  task automatic t_keyHidden;
    wr(4'd0, 32'hFFA5A5FF);
    rdChk("R3 key not readable", 4'd0, 32'd1);
    wr(4'd4, 32'h1);
    idleNoPulse("R8 write of 1 no pulse", 3);
    rdChk("R8 still unlocked", 4'd0, 32'd1);
    rdChk("R8 soft bit 1", 4'd4, 32'd1);
  endtask

  task automatic t_pulse;
    int n = 0;
    wr(4'd0, GOOD);
    wr(4'd4, 32'hFFFFFFFE);
    chk("R6 request rises after write", 32'(chipRstReq), 32'd1);
    countHigh(n);
    chk("R6 pulse length", 32'(n), 32'(PLEN));
    rdChk("R7 relocked", 4'd0, 32'd0);
    rdChk("R7 soft bit restored", 4'd4, 32'd1);
    wr(4'd4, 32'h0);
    idleNoPulse("R7 new unlock needed", 3);
  endtask

  task automatic t_busy;
    int n = 0;
    wr(4'd0, GOOD);
    wr(4'd4, 32'h0);
    n++; rdChk("R6 soft bit reads 0 in pulse", 4'd4, 32'd0);
    n++; rdChk("R9 lock held in pulse", 4'd0, 32'd1);
    n++; wr(4'd0, 32'h00000000);
    n++; rdChk("R9 bad key ignored in pulse", 4'd0, 32'd1);
    n++; wr(4'd4, 32'h0);
    n++; wr(4'd0, GOOD);
    countHigh(n);
    chk("R9 pulse not extended", 32'(n), 32'(PLEN));
    rdChk("R9 unlock in pulse ignored", 4'd0, 32'd0);
    wr(4'd4, 32'h0);
    idleNoPulse("R9 no retrigger", 3);
  endtask

  task automatic t_otherOff;
    wr(4'd0, GOOD);
    wr(4'd8, 32'h0);
    wr(4'd5, 32'h0);
    wr(4'd12, GOOD);
    idleNoPulse("R10 unmapped writes no pulse", 2);
    rdChk("R10 offset 8 reads 0", 4'd8, 32'd0);
    rdChk("R10 offset 5 reads 0", 4'd5, 32'd0);
    rdChk("R10 lock unchanged", 4'd0, 32'd1);
    rdChk("R10 soft bit unchanged", 4'd4, 32'd1);
    wr(4'd1, 32'h0);
    rdChk("R10 unaligned write ignored", 4'd0, 32'd1);
    wr(4'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_badKeys();
    t_keyHidden();
    t_pulse();
    t_busy();
    t_otherOff();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule